// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits behind a windowed region of the CPU address map that software uses to reach the configuration space of devices on the south side of a PCI host bridge. Each CPU access into that window carries only a short offset. The block joins that offset to an upper half held in a mapping register, and reads the result as a type-0 configuration address. In that address a one-hot field selects the target device, followed by a function number and a register number. From these fields it forms the configuration-cycle address that the bus engine will issue, with the enable bit set.

A translation can fail in three ways: software has disabled it through a bit in the mapping register, the request itself is malformed, or no device-select bit is set. In each case no cycle is issued. The block raises a one-cycle indication of the cause instead, and a read gets all-ones data sized to the access width. Every cycle that is issued also tells the bridge to clear its received-master-abort and received-target-abort status bits. All results are registered and appear one clock after the request. The bus cycle itself is handled elsewhere.

Top module: `cfgx_translator`

## Requirements
- R1: When bit 16 of `map_reg` is set, a request pulses `refused` and issues no cycle. A read then returns `rd_ones` sized to the access: size code 0 gives 0x000000FF, code 1 gives 0x0000FFFF, codes 2 and 3 give 0xFFFFFFFF. A write returns no data (`rd_ones_valid` low).
- R2: The combined 32-bit address takes `req_addr[15:0]` as its low half and `map_reg[15:0]` as its high half.
- R3: The device number is the index of the lowest set bit of combined bits [31:11], counted from bit 11. For example, combined bit 17 alone gives device 6, and bits 31 and 16 together give device 5.
- R4: The function number comes from combined bits [10:8]. The register number comes from combined bits [7:2] and stays at those positions; output bits [1:0] are zero.
- R5: An issued cycle presents `cfg_addr` with bit 31 = 1, bits [30:24] = 0, bits [23:16] = `bus_num`, [15:11] = device, [10:8] = function and [7:2] = register, with `cfg_valid` high.
- R6: If the translation is not disabled, the request is well formed and combined bits [31:11] are all zero, the block pulses `idsel_err` for one cycle and issues no cycle. A read gets sized all-ones data as in R1; a write gets none.
- R7: Every issued cycle, read or write, pulses `clr_abort` in the same cycle as `cfg_valid`.
- R8: Size codes 0, 1 and 2 (1, 2 and 4 bytes) are accepted. Size code 3, or read and write requested together, pulses `bad_req` and issues no cycle; a read then returns 0xFFFFFFFF.
- R9: All results appear exactly one clock after the request. `cfg_we` is high for a write and `cfg_size` echoes the size code. At most one of `cfg_valid`, `refused`, `bad_req` and `idsel_err` is high at a time. The priority is disable first, then malformed request, then zero device select. A cycle with no request leaves all of these low.
- R10: A synchronous active-high `rst` clears every strobe and `cfg_addr`. A request made while reset is high produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read request into the window, one cycle |
| req_wr | input | 1 | Write request into the window, one cycle |
| req_addr | input | 16 | Low offset of the access |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 illegal |
| map_reg | input | 32 | Mapping register: [15:0] upper address, [16] disable |
| bus_num | input | 8 | Bus number placed in the cycle address |
| cfg_valid | output | 1 | Configuration cycle issued |
| cfg_we | output | 1 | Issued cycle is a write |
| cfg_size | output | 2 | Size code of the issued cycle |
| cfg_addr | output | 32 | Configuration cycle address |
| clr_abort | output | 1 | Clear the received master/target abort status |
| refused | output | 1 | Translation disabled by the mapping register |
| bad_req | output | 1 | Illegal size or conflicting strobes |
| idsel_err | output | 1 | No device-select bit set |
| rd_ones_valid | output | 1 | All-ones read data returned |
| rd_ones | output | 32 | Sized all-ones read data |

## Verification
The bench builds the block with its default parameters: a 16-bit offset and a 16-bit mapping half, which give a 21-bit device-select field, an 8-bit bus number and 32-bit data. With these values it can place device-select bits at the lowest position (bit 11), in the middle, and at bit 31, the top position. This covers device numbers 0 through 20, including a field with several bits set, where the lowest bit must win. The 32-bit data width makes all three legal sized all-ones masks observable, along with the full mask for illegal sizes. The priority among disable, malformed request and zero device select is also tested.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  // Positions fixed by the configuration address format.
  localparam int CFG_ADDR_W  = 32;
  localparam int EN_BIT      = 31;
  localparam int BUS_LSB     = 16;
  localparam int DEV_LSB     = 11;
  localparam int DEV_W       = 5;
  localparam int FN_LSB      = 8;
  localparam int FN_W        = 3;
  localparam int REG_LSB     = 2;
  localparam int REG_W       = 6;
  localparam int IDSEL_LSB   = 11;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_code_e;

  // Decoded request class, one bit per outcome.
  typedef struct packed {
    logic accept;
    logic refuse;
    logic malformed;
    logic no_dev;
  } outcome_t;

endpackage

// File: rtl/cfgx_addr_split.sv
module cfgx_addr_split
  import cfgx_pkg::*;
#(
  parameter int LOW_W   = 16,
  parameter int MAP_W   = 16,
  localparam int COMB_W  = LOW_W + MAP_W,
  localparam int IDSEL_W = COMB_W - IDSEL_LSB
) (
  input  logic [LOW_W-1:0]   low_addr,
  input  logic [MAP_W-1:0]   map_hi,
  output logic [IDSEL_W-1:0] idsel,
  output logic [FN_W-1:0]    fn_num,
  output logic [7:0]         reg_off
);

  logic [COMB_W-1:0] combined;
  logic              unused_low;

  // R2: offset in the low half, mapping bits in the high half
  assign combined = {map_hi, low_addr};

  assign idsel   = combined[COMB_W-1:IDSEL_LSB];
  assign fn_num  = combined[FN_LSB +: FN_W];
  // R4: register number stays in place, low two bits forced to zero
  assign reg_off = {combined[REG_LSB +: REG_W], 2'b00};

  assign unused_low = ^combined[REG_LSB-1:0];

endmodule

// File: rtl/cfgx_lsb_index.sv
module cfgx_lsb_index #(
  parameter int W     = 21,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             none
);

  logic [W-1:0] iso;

  // Keep only the lowest set bit (two's complement trick).
  assign iso  = vec & (~vec + W'(1));
  assign none = ~|vec;

  // Encode the isolated bit: index bit j is the OR of positions with bit j set.
  for (genvar j = 0; j < IDX_W; j++) begin : g_bit
    logic [W-1:0] sel;
    for (genvar i = 0; i < W; i++) begin : g_pos
      assign sel[i] = iso[i] & 1'(((i >> j) & 1));
    end
    assign idx[j] = |sel;
  end

endmodule

// File: rtl/cfgx_resp_reg.sv
module cfgx_resp_reg
  import cfgx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take,
  input  outcome_t              oc,
  input  logic                  we_in,
  input  logic [1:0]            size_in,
  input  logic [CFG_ADDR_W-1:0] addr_in,
  input  logic                  ones_en,
  input  logic [DATA_W-1:0]     ones_in,
  output logic                  cfg_valid,
  output logic                  cfg_we,
  output logic [1:0]            cfg_size,
  output logic [CFG_ADDR_W-1:0] cfg_addr,
  output logic                  clr_abort,
  output logic                  refused,
  output logic                  bad_req,
  output logic                  idsel_err,
  output logic                  rd_ones_valid,
  output logic [DATA_W-1:0]     rd_ones
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_valid     <= 1'b0;
      cfg_we        <= 1'b0;
      cfg_size      <= 2'd0;
      cfg_addr      <= '0;
      clr_abort     <= 1'b0;
      refused       <= 1'b0;
      bad_req       <= 1'b0;
      idsel_err     <= 1'b0;
      rd_ones_valid <= 1'b0;
      rd_ones       <= '0;
    end else begin
      cfg_valid     <= take & oc.accept;
      clr_abort     <= take & oc.accept;
      refused       <= take & oc.refuse;
      bad_req       <= take & oc.malformed;
      idsel_err     <= take & oc.no_dev;
      rd_ones_valid <= take & ones_en;
      rd_ones       <= (take & ones_en) ? ones_in : '0;
      if (take & oc.accept) begin
        cfg_we   <= we_in;
        cfg_size <= size_in;
        cfg_addr <= addr_in;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_valid, refused, bad_req, idsel_err})); // R9

  AST_ONES_NOT_WITH_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_ones_valid |-> !cfg_valid); // R1

endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
  import cfgx_pkg::*;
#(
  parameter int LOW_W       = 16,
  parameter int MAP_W       = 16,
  parameter int MAP_REG_W   = 32,
  parameter int DISABLE_BIT = 16,
  parameter int BUS_W       = 8,
  parameter int DATA_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_rd,
  input  logic                  req_wr,
  input  logic [LOW_W-1:0]      req_addr,
  input  logic [1:0]            req_size,
  input  logic [MAP_REG_W-1:0]  map_reg,
  input  logic [BUS_W-1:0]      bus_num,
  output logic                  cfg_valid,
  output logic                  cfg_we,
  output logic [1:0]            cfg_size,
  output logic [CFG_ADDR_W-1:0] cfg_addr,
  output logic                  clr_abort,
  output logic                  refused,
  output logic                  bad_req,
  output logic                  idsel_err,
  output logic                  rd_ones_valid,
  output logic [DATA_W-1:0]     rd_ones
);

  localparam int COMB_W  = LOW_W + MAP_W;
  localparam int IDSEL_W = COMB_W - IDSEL_LSB;
  localparam int IDX_W   = (IDSEL_W > 1) ? $clog2(IDSEL_W) : 1;
  localparam int LANES   = DATA_W / 8;

  logic [IDSEL_W-1:0]    idsel;
  logic [FN_W-1:0]       fn_num;
  logic [7:0]            reg_off;
  logic [IDX_W-1:0]      dev_idx;
  logic                  idsel_none;
  logic                  any_req;
  logic                  disabled;
  logic                  malformed;
  outcome_t              oc;
  logic [CFG_ADDR_W-1:0] addr_nx;
  logic [LANES-1:0]      lane_on;
  logic [DATA_W-1:0]     sized_mask;
  logic [DATA_W-1:0]     ones_nx;
  logic                  ones_en;
  logic                  unused_map;

  assign unused_map = ^map_reg;

  cfgx_addr_split #(
    .LOW_W (LOW_W),
    .MAP_W (MAP_W)
  ) u_split (
    .low_addr (req_addr),
    .map_hi   (map_reg[MAP_W-1:0]),
    .idsel    (idsel),
    .fn_num   (fn_num),
    .reg_off  (reg_off)
  );

  // R3: device number is the lowest set device-select bit
  cfgx_lsb_index #(
    .W (IDSEL_W)
  ) u_dev (
    .vec  (idsel),
    .idx  (dev_idx),
    .none (idsel_none)
  );

  // Outcome decode; priority: disable, malformed, no device.
  assign any_req   = req_rd | req_wr;
  assign disabled  = map_reg[DISABLE_BIT];
  assign malformed = (req_size == SZ_BAD) | (req_rd & req_wr);

  always_comb begin
    oc           = '0;
    oc.refuse    = disabled;
    oc.malformed = !disabled & malformed;
    oc.no_dev    = !disabled & !malformed & idsel_none;
    oc.accept    = !disabled & !malformed & !idsel_none;
  end

  // R5: cycle address layout with the enable bit set
  always_comb begin
    addr_nx                    = '0;
    addr_nx[EN_BIT]            = 1'b1;
    addr_nx[BUS_LSB +: BUS_W]  = bus_num;
    addr_nx[DEV_LSB +: DEV_W]  = DEV_W'(dev_idx);
    addr_nx[FN_LSB +: FN_W]    = fn_num;
    addr_nx[7:0]               = reg_off;
  end

  // Sized all-ones data: lane b is on when it lies inside the access width.
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_on[b] = (req_size == SZ_BAD) || (b < (1 << req_size));
    assign sized_mask[b*8 +: 8] = {8{lane_on[b]}};
  end

  assign ones_nx = oc.malformed ? '1 : sized_mask;
  assign ones_en = req_rd & !oc.accept;

  cfgx_resp_reg #(
    .DATA_W (DATA_W)
  ) u_resp (
    .clk           (clk),
    .rst           (rst),
    .take          (any_req),
    .oc            (oc),
    .we_in         (req_wr),
    .size_in       (req_size),
    .addr_in       (addr_nx),
    .ones_en       (ones_en),
    .ones_in       (ones_nx),
    .cfg_valid     (cfg_valid),
    .cfg_we        (cfg_we),
    .cfg_size      (cfg_size),
    .cfg_addr      (cfg_addr),
    .clr_abort     (clr_abort),
    .refused       (refused),
    .bad_req       (bad_req),
    .idsel_err     (idsel_err),
    .rd_ones_valid (rd_ones_valid),
    .rd_ones       (rd_ones)
  );

  AST_DISABLE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (any_req && disabled) |=> (refused && !cfg_valid)); // R1

  AST_NO_DEV_FLAG: assert property (@(posedge clk) disable iff (rst)
    (any_req && !disabled && !malformed && (idsel == '0)) |=> (idsel_err && !cfg_valid)); // R6

  AST_CLEAR_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (any_req && !disabled && !malformed && (idsel != '0)) |=> (cfg_valid && clr_abort)); // R7

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (cfg_addr[EN_BIT] && (cfg_addr[1:0] == 2'b00))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !any_req |=> !(cfg_valid || refused || bad_req || idsel_err)); // R9

  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
    (any_req && !disabled && (req_size == SZ_BAD)) |=> (bad_req && !cfg_valid)); // R8

endmodule

// File: tb/cfgx_translator_tb.sv
module cfgx_translator_tb;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [15:0] addr;
    logic [1:0]  sz;
    logic [31:0] map;
    logic [7:0]  bus;
    logic [2:0]  kind;   // 1 issued, 2 refused, 3 bad, 4 no device
    logic [31:0] exp_addr;
    logic        ones_v;
    logic [31:0] ones;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,16'h0808,2'd2,32'h00000000,8'h00,3'd1,32'h80000008,1'b0,32'h0},
    '{1'b0,1'b1,16'h0000,2'd1,32'h00000002,8'h03,3'd1,32'h80033000,1'b0,32'h0},
    '{1'b1,1'b0,16'h0734,2'd2,32'h00000010,8'h1F,3'd1,32'h801F4F34,1'b0,32'h0},
    '{1'b1,1'b0,16'h03FF,2'd0,32'h00008001,8'hA5,3'd1,32'h80A52BFC,1'b0,32'h0},
    '{1'b0,1'b1,16'h0001,2'd1,32'h00008000,8'hFF,3'd1,32'h80FFA000,1'b0,32'h0},
    '{1'b1,1'b0,16'h0100,2'd0,32'h00010002,8'h00,3'd2,32'h0,1'b1,32'h000000FF},
    '{1'b1,1'b0,16'h0100,2'd1,32'h00010000,8'h00,3'd2,32'h0,1'b1,32'h0000FFFF},
    '{1'b0,1'b1,16'h0100,2'd2,32'h00010002,8'h00,3'd2,32'h0,1'b0,32'h0},
    '{1'b1,1'b0,16'h07FC,2'd2,32'h00000000,8'h00,3'd4,32'h0,1'b1,32'hFFFFFFFF},
    '{1'b0,1'b1,16'h07FC,2'd0,32'h00000000,8'h00,3'd4,32'h0,1'b0,32'h0},
    '{1'b1,1'b0,16'h0800,2'd3,32'h00000002,8'h00,3'd3,32'h0,1'b1,32'hFFFFFFFF},
    '{1'b1,1'b1,16'h0800,2'd2,32'h00000002,8'h00,3'd3,32'h0,1'b1,32'hFFFFFFFF},
    '{1'b1,1'b0,16'h0800,2'd3,32'h00010002,8'h00,3'd2,32'h0,1'b1,32'hFFFFFFFF},
    '{1'b1,1'b0,16'h0000,2'd1,32'h00010000,8'h00,3'd2,32'h0,1'b1,32'h0000FFFF},
    '{1'b0,1'b1,16'h0000,2'd3,32'h00000000,8'h00,3'd3,32'h0,1'b0,32'h0},
    '{1'b1,1'b0,16'h0004,2'd0,32'h00000000,8'h00,3'd4,32'h0,1'b1,32'h000000FF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_rd = 1'b0;
  logic        req_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] map_reg = '0;
  logic [7:0]  bus_num = '0;
  logic        cfg_valid, cfg_we, clr_abort, refused, bad_req, idsel_err, rd_ones_valid;
  logic [1:0]  cfg_size;
  logic [31:0] cfg_addr, rd_ones;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cfgx_translator u_dut (
    .clk (clk), .rst (rst), .req_rd (req_rd), .req_wr (req_wr),
    .req_addr (req_addr), .req_size (req_size), .map_reg (map_reg),
    .bus_num (bus_num), .cfg_valid (cfg_valid), .cfg_we (cfg_we),
    .cfg_size (cfg_size), .cfg_addr (cfg_addr), .clr_abort (clr_abort),
    .refused (refused), .bad_req (bad_req), .idsel_err (idsel_err),
    .rd_ones_valid (rd_ones_valid), .rd_ones (rd_ones)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_rd = v.rd; req_wr = v.wr; req_addr = v.addr;
    req_size = v.sz; map_reg = v.map; bus_num = v.bus;
  endtask

  task automatic idle();
    req_rd = 1'b0; req_wr = 1'b0;
  endtask

  task automatic check_result(input int n, input vec_t v);
    string tg;
    tg = $sformatf("vec %0d", n);
    chk({tg, " R5 valid"},     32'(cfg_valid), 32'(v.kind == 3'd1));
    chk({tg, " R1 refused"},   32'(refused),   32'(v.kind == 3'd2));
    chk({tg, " R8 bad"},       32'(bad_req),   32'(v.kind == 3'd3));
    chk({tg, " R6 idsel"},     32'(idsel_err), 32'(v.kind == 3'd4));
    chk({tg, " R7 clr_abort"}, 32'(clr_abort), 32'(v.kind == 3'd1));
    chk({tg, " R1 ones_valid"}, 32'(rd_ones_valid), 32'(v.ones_v));
    if (v.kind == 3'd1) begin
      chk({tg, " R2 R3 R4 R5 addr"}, cfg_addr, v.exp_addr);
      chk({tg, " R9 we"},   32'(cfg_we),   32'(v.wr));
      chk({tg, " R9 size"}, 32'(cfg_size), 32'(v.sz));
    end
    if (v.ones_v) chk({tg, " R1 R6 R8 ones"}, rd_ones, v.ones);
  endtask

  task automatic check_quiet(input string tg);
    chk({tg, " R9 quiet"}, 32'({cfg_valid, refused, bad_req, idsel_err, clr_abort, rd_ones_valid}), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset strobes", 32'({cfg_valid, refused, bad_req, idsel_err, clr_abort, rd_ones_valid}), 32'h0);
    chk("R10 reset addr", cfg_addr, 32'h0);
    rst = 1'b0;

    // Vector table
    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      drive(VECS[n]);
      @(negedge clk);
      idle();
      check_result(n, VECS[n]);
      @(negedge clk);
      check_quiet($sformatf("vec %0d idle", n));
    end

    // R9: back-to-back requests, each result one clock later
    @(negedge clk);
    drive(VECS[2]);
    @(negedge clk);
    check_result(100, VECS[2]);
    drive(VECS[4]);
    @(negedge clk);
    idle();
    check_result(101, VECS[4]);
    @(negedge clk);
    check_quiet("back-to-back");

    // R9: refusal right after an issued cycle clears valid the next clock
    drive(VECS[0]);
    @(negedge clk);
    drive(VECS[5]);
    @(negedge clk);
    idle();
    check_result(102, VECS[5]);

    // R10: request during reset produces nothing
    @(negedge clk);
    rst = 1'b1;
    drive(VECS[1]);
    @(negedge clk);
    idle();
    chk("R10 req in reset valid", 32'(cfg_valid), 32'h0);
    chk("R10 req in reset addr", cfg_addr, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check_quiet("after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule